// File: doc/BRIEF.md
# Shared SPI Bus Router

This block lets a single SPI master drive several electrically separate SPI buses, one per board section. The master supplies its serial clock, its outgoing data, one active-low select and a 4-bit device code. The router uses the device code to decide which bus and which select line on that bus should carry the transfer. Every outgoing signal passes through two register stages. Both stages advance only on a clock enable that pulses at twice the SCLK rate, so the path adds exactly one SCLK period. The master is set up to allow for that delay.

Three buses are served. The converter bus has one select, the transceiver bus has two and the auxiliary bus has three. A bus that is not addressed keeps its SCLK at the idle level given by the clock polarity input, drives its data line low and keeps all its selects high. This means no other slave ever sees a clock edge. The returned data line of the addressed bus is sent back to the master through a matching two-stage path. Some slaves have no return line, so a bus that is not addressed, and any code that is not assigned, returns 0.

Top module: `spi_bus_router`

## Requirements
- R1: While reset is asserted and right after it is released, every bus select is high (1), every bus SCLK and data line is 0, and the returned data to the master is 0.
- R2: A change on the master's select, SCLK or data reaches the bus outputs on the second clock-enabled edge after it is applied. It is not visible after only the first such edge.
- R3: Device code 0000 routes the transfer to the converter bus. Its single select follows the master select, and its SCLK and data follow the master.
- R4: Device code 0010 drives select bit 0 of the transceiver bus low and code 0011 drives select bit 1 low, while the master select is low.
- R5: Device codes 0100, 0101 and 0110 drive select bits 0, 1 and 2 of the auxiliary bus low, in that order, while the master select is low.
- R6: Every bus that is not addressed holds its SCLK at the clock polarity input value (0 or 1), drives its data line 0 and keeps all its selects high.
- R7: Any unassigned code (0001, 0111 to 1111) asserts no select on any bus and leaves every bus idle as in R6. At most one select is low across all buses at any time.
- R8: Cycles without the clock enable change no output.
- R9: The returned data to the master is the data line of the addressed bus, delayed by two clock-enabled edges. It is 0 for a bus that is not addressed and for an unassigned code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| x2_ce | input | 1 | Clock enable at twice the SCLK rate; advances both stages |
| cpol | input | 1 | Idle SCLK level for buses that are not addressed |
| m_sclk | input | 1 | SCLK from the master |
| m_mosi | input | 1 | Outgoing data from the master |
| m_cs_n | input | 1 | Active-low select from the master |
| m_code | input | 4 | Device code echoed by the master |
| m_miso | output | 1 | Returned data to the master |
| conv_sclk | output | 1 | Converter bus SCLK |
| conv_mosi | output | 1 | Converter bus outgoing data |
| conv_cs_n | output | 1 | Converter bus select, active low |
| conv_miso | input | 1 | Converter bus returned data |
| trx_sclk | output | 1 | Transceiver bus SCLK |
| trx_mosi | output | 1 | Transceiver bus outgoing data |
| trx_cs_n | output | 2 | Transceiver bus selects, active low |
| trx_miso | input | 1 | Transceiver bus returned data |
| aux_sclk | output | 1 | Auxiliary bus SCLK |
| aux_mosi | output | 1 | Auxiliary bus outgoing data |
| aux_cs_n | output | 3 | Auxiliary bus selects, active low |
| aux_miso | input | 1 | Auxiliary bus returned data |

## Verification
The assertions assume that the clock enable is the only thing that advances the path. They also assume that the master keeps its device code and polarity steady between enable pulses, so that a registered decode describes one whole transfer. The bench follows these rules. It changes inputs only on falling clock edges with the enable low, and then issues each enable as a single-cycle pulse. It checks outputs after a counted number of pulses, so that the one-period latency is measured and not assumed.

// File: rtl/spi_bus_router.sv
module spi_bus_router #(
  parameter int CODE_W = 4,
  parameter int TRX_N = 2,
  parameter int AUX_N = 3,
  parameter logic [CODE_W-1:0] CONV_CODE = 4'h0,
  parameter logic [CODE_W-1:0] TRX_BASE = 4'h2,
  parameter logic [CODE_W-1:0] AUX_BASE = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x2_ce,
  input  logic              cpol,
  input  logic              m_sclk,
  input  logic              m_mosi,
  input  logic              m_cs_n,
  input  logic [CODE_W-1:0] m_code,
  output logic              m_miso,
  output logic              conv_sclk,
  output logic              conv_mosi,
  output logic              conv_cs_n,
  input  logic              conv_miso,
  output logic              trx_sclk,
  output logic              trx_mosi,
  output logic [TRX_N-1:0]  trx_cs_n,
  input  logic              trx_miso,
  output logic              aux_sclk,
  output logic              aux_mosi,
  output logic [AUX_N-1:0]  aux_cs_n,
  input  logic              aux_miso
);

  localparam logic [CODE_W-1:0] TRX_CNT = CODE_W'(TRX_N);
  localparam logic [CODE_W-1:0] AUX_CNT = CODE_W'(AUX_N);

  logic              s1_sclk, s1_mosi, s1_cs_n, s1_cpol;
  logic [CODE_W-1:0] s1_code, s2_code;
  logic              miso_s1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_sclk <= 1'b0;
      s1_mosi <= 1'b0;
      s1_cs_n <= 1'b1;
      s1_cpol <= 1'b0;
      s1_code <= '1;
    end else if (x2_ce) begin
      s1_sclk <= m_sclk;
      s1_mosi <= m_mosi;
      s1_cs_n <= m_cs_n;
      s1_cpol <= cpol;
      s1_code <= m_code;
    end
  end

  logic [CODE_W-1:0] trx_idx, aux_idx;
  logic              hit_conv, hit_trx, hit_aux;
  assign trx_idx  = s1_code - TRX_BASE;
  assign aux_idx  = s1_code - AUX_BASE;
  assign hit_conv = (s1_code == CONV_CODE);
  assign hit_trx  = (s1_code >= TRX_BASE) && (trx_idx < TRX_CNT);
  assign hit_aux  = (s1_code >= AUX_BASE) && (aux_idx < AUX_CNT);

  logic [TRX_N-1:0] trx_cs_d;
  logic [AUX_N-1:0] aux_cs_d;
  for (genvar i = 0; i < TRX_N; i++) begin : g_trx_sel
    assign trx_cs_d[i] = !(hit_trx && !s1_cs_n && trx_idx == CODE_W'(i));
  end
  for (genvar i = 0; i < AUX_N; i++) begin : g_aux_sel
    assign aux_cs_d[i] = !(hit_aux && !s1_cs_n && aux_idx == CODE_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_sclk <= 1'b0;
      conv_mosi <= 1'b0;
      conv_cs_n <= 1'b1;
      trx_sclk  <= 1'b0;
      trx_mosi  <= 1'b0;
      trx_cs_n  <= '1;
      aux_sclk  <= 1'b0;
      aux_mosi  <= 1'b0;
      aux_cs_n  <= '1;
      s2_code   <= '1;
    end else if (x2_ce) begin
      conv_sclk <= hit_conv ? s1_sclk : s1_cpol;
      conv_mosi <= hit_conv & s1_mosi;
      conv_cs_n <= !(hit_conv && !s1_cs_n);
      trx_sclk  <= hit_trx ? s1_sclk : s1_cpol;
      trx_mosi  <= hit_trx & s1_mosi;
      trx_cs_n  <= trx_cs_d;
      aux_sclk  <= hit_aux ? s1_sclk : s1_cpol;
      aux_mosi  <= hit_aux & s1_mosi;
      aux_cs_n  <= aux_cs_d;
      s2_code   <= s1_code;
    end
  end

  logic [CODE_W-1:0] r_trx_idx, r_aux_idx;
  logic              miso_pick;
  assign r_trx_idx = s2_code - TRX_BASE;
  assign r_aux_idx = s2_code - AUX_BASE;
  always_comb begin
    if (s2_code == CONV_CODE)                               miso_pick = conv_miso;
    else if (s2_code >= TRX_BASE && r_trx_idx < TRX_CNT)    miso_pick = trx_miso;
    else if (s2_code >= AUX_BASE && r_aux_idx < AUX_CNT)    miso_pick = aux_miso;
    else                                                    miso_pick = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miso_s1 <= 1'b0;
      m_miso  <= 1'b0;
    end else if (x2_ce) begin
      miso_s1 <= miso_pick;
      m_miso  <= miso_s1;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !x2_ce |=> $stable({conv_cs_n, trx_cs_n, aux_cs_n, conv_sclk, trx_sclk, aux_sclk, m_miso}));

  assert_single_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~conv_cs_n, ~trx_cs_n, ~aux_cs_n}) <= 1);

  assert_idle_sclk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (x2_ce && !hit_trx) |=> (trx_sclk == $past(s1_cpol) && trx_cs_n == '1 && !trx_mosi));

  assert_miso_unknown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (x2_ce && s2_code > AUX_BASE + AUX_CNT - 1) |=> !miso_s1);

endmodule

// File: tb/sim_spi_bus_router.sv
module sim_spi_bus_router;
  logic clk = 1'b0, rst_n = 1'b0, x2_ce = 1'b0, cpol = 1'b0;
  logic m_sclk = 1'b0, m_mosi = 1'b0, m_cs_n = 1'b1;
  logic [3:0] m_code = 4'h0;
  logic m_miso;
  logic conv_sclk, conv_mosi, conv_cs_n, conv_miso = 1'b0;
  logic trx_sclk, trx_mosi, trx_miso = 1'b0;
  logic [1:0] trx_cs_n;
  logic aux_sclk, aux_mosi, aux_miso = 1'b0;
  logic [2:0] aux_cs_n;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  spi_bus_router u0 (.clk, .rst_n, .x2_ce, .cpol, .m_sclk, .m_mosi, .m_cs_n, .m_code, .m_miso,
    .conv_sclk, .conv_mosi, .conv_cs_n, .conv_miso, .trx_sclk, .trx_mosi, .trx_cs_n, .trx_miso,
    .aux_sclk, .aux_mosi, .aux_cs_n, .aux_miso);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) x2_ce = 1'b1;
      @(negedge clk) x2_ce = 1'b0;
    end
  endtask

  task automatic drive(logic [3:0] code, logic cs, logic sck, logic d);
    @(negedge clk);
    m_code = code; m_cs_n = cs; m_sclk = sck; m_mosi = d;
  endtask

  task automatic t_reset;
    chk("R1 selects", {conv_cs_n, trx_cs_n, aux_cs_n}, 6'h3f);
    chk("R1 sclk/mosi", {conv_sclk, trx_sclk, aux_sclk, conv_mosi, trx_mosi, aux_mosi}, 6'h0);
    chk("R1 miso", m_miso, 0);
  endtask

  task automatic t_conv;
    drive(4'h0, 1'b0, 1'b1, 1'b1);
    pulse(1);
    chk("R2 not after one enable", conv_cs_n, 1);
    pulse(1);
    chk("R2 after two enables", conv_cs_n, 0);
    chk("R3 conv sclk/mosi", {conv_sclk, conv_mosi}, 2'b11);
    chk("R6 others idle", {trx_sclk, aux_sclk, trx_mosi, aux_mosi, trx_cs_n, aux_cs_n}, 9'b0000_11111);
    drive(4'h0, 1'b1, 1'b0, 1'b0);
    pulse(2);
    chk("R3 conv deselect", conv_cs_n, 1);
  endtask

  task automatic t_trx;
    drive(4'h2, 1'b0, 1'b1, 1'b1); pulse(2);
    chk("R4 code 0010", trx_cs_n, 2'b10);
    chk("R6 conv mosi off", {conv_mosi, conv_cs_n}, 2'b01);
    drive(4'h3, 1'b0, 1'b1, 1'b1); pulse(2);
    chk("R4 code 0011", trx_cs_n, 2'b01);
    chk("R4 trx sclk", trx_sclk, 1);
  endtask

  task automatic t_aux;
    for (int c = 4; c < 7; c++) begin
      drive(4'(c), 1'b0, 1'b0, 1'b1); pulse(2);
      chk("R5 aux select", aux_cs_n, 3'(~(3'b001 << (c - 4))));
      chk("R5 aux mosi", aux_mosi, 1);
    end
  endtask

  task automatic t_unknown;
    logic [3:0] codes [3] = '{4'h1, 4'h7, 4'hf};
    for (int i = 0; i < 3; i++) begin
      drive(codes[i], 1'b0, 1'b1, 1'b1); pulse(2);
      chk("R7 no select", {conv_cs_n, trx_cs_n, aux_cs_n}, 6'h3f);
      chk("R7 idle buses", {conv_sclk, trx_sclk, aux_sclk, conv_mosi, trx_mosi, aux_mosi}, 6'h0);
    end
  endtask

  task automatic t_cpol;
    cpol = 1'b1;
    drive(4'h2, 1'b0, 1'b0, 1'b0); pulse(2);
    chk("R6 idle high on unaddressed", {conv_sclk, aux_sclk}, 2'b11);
    chk("R6 addressed follows master", trx_sclk, 0);
    cpol = 1'b0;
    drive(4'h2, 1'b1, 1'b0, 1'b0); pulse(2);
  endtask

  task automatic t_hold;
    drive(4'h5, 1'b0, 1'b1, 1'b1); pulse(2);
    drive(4'h0, 1'b0, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    chk("R8 aux select held", aux_cs_n, 3'b101);
    chk("R8 conv held", {conv_cs_n, aux_sclk}, 2'b11);
  endtask

  task automatic t_miso;
    drive(4'h5, 1'b0, 1'b0, 1'b0); pulse(2);
    aux_miso = 1'b1; conv_miso = 1'b0; trx_miso = 1'b0;
    pulse(1);
    chk("R9 miso delay one", m_miso, 0);
    pulse(1);
    chk("R9 miso from aux", m_miso, 1);
    aux_miso = 1'b0; conv_miso = 1'b1; trx_miso = 1'b1;
    pulse(2);
    chk("R9 unaddressed miso ignored", m_miso, 0);
    aux_miso = 1'b1;
    drive(4'h9, 1'b0, 1'b0, 1'b0); pulse(4);
    chk("R9 unknown code returns 0", m_miso, 0);
    drive(4'h3, 1'b0, 1'b0, 1'b0); pulse(4);
    chk("R9 miso from trx", m_miso, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_conv();
    t_trx();
    t_aux();
    t_unknown();
    t_cpol();
    t_hold();
    t_miso();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule